// File: doc/BRIEF.md
# Microstepping Step-Table Indexer

This block converts a step/direction command stream into signed current set-points for the two windings of a bipolar stepper motor. It walks one 128-entry electrical cycle: entry 0 is 0°, the entries are 2.8125° apart, winding A follows the cosine and winding B follows the sine. Each winding gets a 5-bit magnitude code and a sign bit. A downstream reference DAC and chopper use these set-points, and a decay selector uses the per-winding "current rising" flag.

A 3-bit mode input sets the stride through the table, from every entry (1/32 step) to every 32nd entry (full step). Full step uses only the four diagonal entries, where both windings sit at 71% of full scale. The step input is asynchronous. It passes through a flop synchronizer and is edge-detected in the system clock domain. Reset and power-up place the index on the 45° home entry.

Top module: `stepper_indexer`

## Requirements
- R1: While `rst_ni` is low and right after it rises, the index is 16 (45°). Both magnitudes are 22, both signs are 0, `home_no` is 0 and both rise flags are 0.
- R2: Mode code 000 sets stride 32, 001 stride 16, 010 stride 8, 011 stride 4 and 100 stride 2. Codes 101, 110 and 111 all set stride 1.
- R3: Each accepted step moves the index to the next valid entry in the commanded direction, modulo 128. `dir_i` = 1 moves up the table and `dir_i` = 0 moves down.
- R4: At index i, `mag_a_o` = round(31·|cos(i·2π/128)|) and `mag_b_o` = round(31·|sin(i·2π/128)|). A sign bit is 1 only when its value is strictly negative and its magnitude is nonzero. Sign 0 means the output-1 side of the winding is the positive side.
- R5: In mode 000 the valid entries are 16, 48, 80 and 112. Both magnitudes are 22 on each of them.
- R6: For the stride s of the current mode, the valid entries are those equal to 16 modulo s in mode 000, and multiples of s in every other mode. After a mode change, the next step goes to the nearest valid entry strictly beyond the current index in the step direction, even when that is less than one full stride away.
- R7: A step rising edge has no effect on any output while `enable_ni` is high. `rst_ni` low holds the index at home.
- R8: `home_no` is 0 exactly when the index is 16.
- R9: On every accepted step, each rise flag is loaded with 1 if the new magnitude of its winding is greater than the old one, and with 0 otherwise. The flags hold between steps.
- R10: A rising edge of `step_i` first sampled at clock edge n changes the outputs at clock edge n+2 (two synchronizer flops, then the edge register). A step held high moves the index only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, returns the index to home |
| step_i | input | 1 | Asynchronous step command, acts on its rising edge |
| dir_i | input | 1 | Step direction, 1 = up the table |
| mode_i | input | 3 | Stride select |
| enable_ni | input | 1 | Active-low enable; high ignores steps |
| mag_a_o | output | 5 | Winding A magnitude code |
| neg_a_o | output | 1 | Winding A negative sign |
| mag_b_o | output | 5 | Winding B magnitude code |
| neg_b_o | output | 1 | Winding B negative sign |
| rise_a_o | output | 1 | Winding A magnitude grew on the last step |
| rise_b_o | output | 1 | Winding B magnitude grew on the last step |
| home_no | output | 1 | Low while the index is on the 45° home entry |

## Verification
The bench aims at realignment after a mode change. One case moves one entry off home and then switches to full step. A design that simply adds the new stride would land on 49 instead of 48 going up, and on 113 instead of 16 going down. Other cases cover the zero crossings, where a design that takes the sign from the quadrant alone would flag a negative zero, and wrap-around at both ends of the table, which an index without modulo arithmetic would get wrong. A step held high for many cycles and step pulses sent while disabled catch an edge detector that is level-sensitive or that still advances when the block is disabled. A long stream of pseudo-random modes and directions is compared against an angle-based model on every clock, so any off-by-one in the quarter-wave folding shows up as a wrong magnitude.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;
  localparam int IDX_W      = 7;
  localparam int N_STATES   = 1 << IDX_W;
  localparam int QTR_W      = IDX_W - 2;
  localparam int QTR_STATES = 1 << QTR_W;
  localparam int MAG_W      = 5;
  localparam int STRIDE_LOG_MAX = QTR_W;
  localparam int HOME_IDX   = QTR_STATES / 2;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [MAG_W-1:0] mag_t;

  typedef struct packed {
    logic neg;
    mag_t mag;
  } coil_t;

  // quarter-wave sine, 31 full scale, entry k at k*90/32 degrees
  function automatic mag_t quarter_sine(input logic [QTR_W:0] k);
    mag_t m;
    case (k)
      6'd0:  m = 5'd0;   6'd1:  m = 5'd2;   6'd2:  m = 5'd3;   6'd3:  m = 5'd5;
      6'd4:  m = 5'd6;   6'd5:  m = 5'd8;   6'd6:  m = 5'd9;   6'd7:  m = 5'd10;
      6'd8:  m = 5'd12;  6'd9:  m = 5'd13;  6'd10: m = 5'd15;  6'd11: m = 5'd16;
      6'd12: m = 5'd17;  6'd13: m = 5'd18;  6'd14: m = 5'd20;  6'd15: m = 5'd21;
      6'd16: m = 5'd22;  6'd17: m = 5'd23;  6'd18: m = 5'd24;  6'd19: m = 5'd25;
      6'd20: m = 5'd26;  6'd21: m = 5'd27;  6'd22: m = 5'd27;  6'd23: m = 5'd28;
      6'd24: m = 5'd29;  6'd25: m = 5'd29;  6'd26: m = 5'd30;  6'd27: m = 5'd30;
      6'd28: m = 5'd30;  6'd29: m = 5'd31;  6'd30: m = 5'd31;  6'd31: m = 5'd31;
      6'd32: m = 5'd31;
      default: m = 5'd0;
    endcase
    return m;
  endfunction

  // log2 of the stride for a mode code
  function automatic logic [2:0] stride_log2(input logic [2:0] mode);
    logic [2:0] r;
    if (mode >= 3'd5) r = 3'd0;
    else              r = 3'(STRIDE_LOG_MAX) - mode;
    return r;
  endfunction
endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], step_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/idx_next_calc.sv
module idx_next_calc import stepidx_pkg::*; (
  input  idx_t       idx_i,
  input  logic [2:0] mode_i,
  input  logic       dir_i,
  output idx_t       idx_o
);
  logic [2:0] sh;
  idx_t step_sz, low_mask, ofs, rel, base, fwd, rev;

  always_comb begin
    sh       = stride_log2(mode_i);
    step_sz  = idx_t'(1) << sh;
    low_mask = step_sz - idx_t'(1);
    // full step lives on the diagonal entries
    ofs      = (mode_i == 3'd0) ? idx_t'(HOME_IDX) : '0;
    rel      = idx_i - ofs;
    base     = rel & ~low_mask;
    fwd      = base + step_sz;
    rev      = ((rel & low_mask) == '0) ? (rel - step_sz) : base;
    idx_o    = (dir_i ? fwd : rev) + ofs;
  end
endmodule

// File: rtl/coil_lookup.sv
module coil_lookup import stepidx_pkg::*; #(
  parameter idx_t OFS = '0
) (
  input  idx_t  idx_i,
  output coil_t coil_o
);
  idx_t             ph;
  logic [QTR_W:0]   kk;
  mag_t             m;

  always_comb begin
    ph = idx_i + OFS;
    kk = ph[QTR_W] ? ((QTR_W+1)'(QTR_STATES) - {1'b0, ph[QTR_W-1:0]})
                   : {1'b0, ph[QTR_W-1:0]};
    m  = quarter_sine(kk);
    coil_o.mag = m;
    coil_o.neg = ph[QTR_W+1] & (m != '0);
  end
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer import stepidx_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [2:0]       mode_i,
  input  logic             enable_ni,
  output logic [MAG_W-1:0] mag_a_o,
  output logic             neg_a_o,
  output logic [MAG_W-1:0] mag_b_o,
  output logic             neg_b_o,
  output logic             rise_a_o,
  output logic             rise_b_o,
  output logic             home_no
);
  logic  step_rise, advance;
  idx_t  idx_q, idx_nxt;
  coil_t cur [2];
  coil_t nxt [2];

  step_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .rise_o (step_rise)
  );

  idx_next_calc u_next (
    .idx_i  (idx_q),
    .mode_i (mode_i),
    .dir_i  (dir_i),
    .idx_o  (idx_nxt)
  );

  assign advance = step_rise & ~enable_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= idx_t'(HOME_IDX);
    else if (advance) idx_q <= idx_nxt;
  end

  // winding 0 = A (cosine, quarter offset), winding 1 = B (sine)
  for (genvar w = 0; w < 2; w++) begin : g_coil
    localparam idx_t OFS = (w == 0) ? idx_t'(QTR_STATES) : idx_t'(0);
    logic rise_q;

    coil_lookup #(.OFS(OFS)) u_cur (.idx_i(idx_q),   .coil_o(cur[w]));
    coil_lookup #(.OFS(OFS)) u_nxt (.idx_i(idx_nxt), .coil_o(nxt[w]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rise_q <= 1'b0;
      else if (advance) rise_q <= (nxt[w].mag > cur[w].mag);
    end
  end

  assign mag_a_o  = cur[0].mag;
  assign neg_a_o  = cur[0].neg;
  assign mag_b_o  = cur[1].mag;
  assign neg_b_o  = cur[1].neg;
  assign rise_a_o = g_coil[0].rise_q;
  assign rise_b_o = g_coil[1].rise_q;
  assign home_no  = (idx_q != idx_t'(HOME_IDX));
endmodule

// File: rtl/stepper_indexer_chk.sv
module stepper_indexer_chk import stepidx_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             enable_ni,
  input logic [MAG_W-1:0] mag_a_o,
  input logic             neg_a_o,
  input logic [MAG_W-1:0] mag_b_o,
  input logic             neg_b_o,
  input logic             rise_a_o,
  input logic             rise_b_o,
  input logic             home_no
);
  localparam logic [MAG_W-1:0] DIAG = 5'd22;

  assert_home_levels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !home_no |-> (mag_a_o == DIAG && mag_b_o == DIAG && !neg_a_o && !neg_b_o));

  assert_sign_nonzero_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_a_o |-> (mag_a_o != '0));

  assert_sign_nonzero_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_b_o |-> (mag_b_o != '0));

  assert_hold_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_ni) |-> ($stable(mag_a_o) && $stable(mag_b_o) && $stable(neg_a_o)
                          && $stable(neg_b_o) && $stable(home_no)
                          && $stable(rise_a_o) && $stable(rise_b_o)));

  assert_full_step_diag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 3'd0 && $past(mag_a_o) == DIAG && $past(mag_b_o) == DIAG)
    |-> (mag_a_o == DIAG && mag_b_o == DIAG));

  assert_rise_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_a_o != $past(mag_a_o)) |-> (rise_a_o == (mag_a_o > $past(mag_a_o))));

  assert_rise_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_b_o != $past(mag_b_o)) |-> (rise_b_o == (mag_b_o > $past(mag_b_o))));
endmodule

bind stepper_indexer stepper_indexer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .enable_ni (enable_ni),
  .mag_a_o   (mag_a_o),
  .neg_a_o   (neg_a_o),
  .mag_b_o   (mag_b_o),
  .neg_b_o   (neg_b_o),
  .rise_a_o  (rise_a_o),
  .rise_b_o  (rise_b_o),
  .home_no   (home_no)
);

// File: tb/stepper_indexer_tb_top.sv
module stepper_indexer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       dir = 1'b1;
  logic [2:0] mode = 3'd5;
  logic       en_n = 1'b0;
  logic [4:0] mag_a, mag_b;
  logic       neg_a, neg_b, rise_a, rise_b, home_n;

  always #4 clk = ~clk;

  stepper_indexer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir), .mode_i(mode),
    .enable_ni(en_n), .mag_a_o(mag_a), .neg_a_o(neg_a), .mag_b_o(mag_b),
    .neg_b_o(neg_b), .rise_a_o(rise_a), .rise_b_o(rise_b), .home_no(home_n)
  );

  int checks = 0;
  int errors = 0;
  bit run_cmp = 0;
  bit finished = 0;

  int m_idx = 16, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_ra = 0, m_rb = 0;

  function automatic real ref_val(int i, bit cos_sel);
    real ang;
    ang = 2.0 * 3.14159265358979 * i / 128.0;
    return cos_sel ? $cos(ang) : $sin(ang);
  endfunction

  function automatic int ref_mag(int i, bit cos_sel);
    real v;
    v = ref_val(i, cos_sel);
    if (v < 0.0) v = -v;
    return $rtoi(v * 31.0 + 0.5);
  endfunction

  function automatic int ref_neg(int i, bit cos_sel);
    return (ref_val(i, cos_sel) < 0.0 && ref_mag(i, cos_sel) != 0) ? 1 : 0;
  endfunction

  function automatic int next_state(int i, int md, int d);
    int s, ofs, cand;
    s   = (md == 0) ? 32 : (md == 1) ? 16 : (md == 2) ? 8 : (md == 3) ? 4 : (md == 4) ? 2 : 1;
    ofs = (md == 0) ? 16 : 0;
    for (int j = 1; j <= s; j++) begin
      cand = d ? (i + j) % 128 : (i - j + 128) % 128;
      if (((cand - ofs + 128) % s) == 0) return cand;
    end
    return i;
  endfunction

  // behavioural reference, advanced on the same clock as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 16; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ra = 0; m_rb = 0;
    end else begin
      if (m_s2 == 1 && m_s3 == 0 && !en_n) begin
        int nx;
        nx   = next_state(m_idx, int'(mode), int'(dir));
        m_ra = (ref_mag(nx, 1) > ref_mag(m_idx, 1)) ? 1 : 0;
        m_rb = (ref_mag(nx, 0) > ref_mag(m_idx, 0)) ? 1 : 0;
        m_idx = nx;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(step);
    end
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk_eq("R4", "mag A", int'(mag_a), ref_mag(m_idx, 1));
      chk_eq("R4", "neg A", int'(neg_a), ref_neg(m_idx, 1));
      chk_eq("R4", "mag B", int'(mag_b), ref_mag(m_idx, 0));
      chk_eq("R4", "neg B", int'(neg_b), ref_neg(m_idx, 0));
      chk_eq("R8", "home_no", int'(home_n), (m_idx == 16) ? 0 : 1);
      chk_eq("R9", "rise A", int'(rise_a), m_ra);
      chk_eq("R9", "rise B", int'(rise_b), m_rb);
    end
  end

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); step = 1'b1;
    repeat (hi) @(negedge clk);
    step = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic expect_idx(input string req, input int i);
    chk_eq(req, "mag A at index", int'(mag_a), ref_mag(i, 1));
    chk_eq(req, "neg A at index", int'(neg_a), ref_neg(i, 1));
    chk_eq(req, "mag B at index", int'(mag_b), ref_mag(i, 0));
    chk_eq(req, "neg B at index", int'(neg_b), ref_neg(i, 0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; run_cmp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "mag A in reset", int'(mag_a), 22);
    chk_eq("R1", "mag B in reset", int'(mag_b), 22);
    chk_eq("R1", "signs in reset", int'({neg_a, neg_b}), 0);
    chk_eq("R1", "home_no in reset", int'(home_n), 0);
    chk_eq("R1", "rise flags in reset", int'({rise_a, rise_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lcg;
    lcg = 32'h1234_5678;
    do_reset();
    chk_eq("R1", "home_no after release", int'(home_n), 0);

    // R3 fine steps up, then down through home and below zero
    mode = 3'd5; dir = 1'b1;
    for (int n = 0; n < 20; n++) pulse(3, 4);
    expect_idx("R3", 36);
    dir = 1'b0;
    for (int n = 0; n < 40; n++) pulse(3, 4);
    expect_idx("R3", 124);
    // R3 full turn returns to the same entry
    for (int n = 0; n < 128; n++) pulse(3, 3);
    expect_idx("R3", 124);

    // R2 stride per mode from home
    do_reset();
    mode = 3'd2; dir = 1'b1; pulse(3, 4);
    expect_idx("R2", 24);
    mode = 3'd1; pulse(3, 4);
    expect_idx("R2", 32);
    mode = 3'd3; pulse(3, 4);
    expect_idx("R2", 36);
    mode = 3'd4; pulse(3, 4);
    expect_idx("R2", 38);
    mode = 3'd6; pulse(3, 4);
    expect_idx("R2", 39);
    mode = 3'd7; dir = 1'b0; pulse(3, 4);
    expect_idx("R2", 38);

    // R5 full step cycles through the diagonals
    do_reset();
    mode = 3'd0; dir = 1'b1;
    for (int n = 0; n < 4; n++) begin
      pulse(3, 4);
      chk_eq("R5", "full step mag A", int'(mag_a), 22);
      chk_eq("R5", "full step mag B", int'(mag_b), 22);
    end
    chk_eq("R5", "full step back home", int'(home_n), 0);

    // R6 realignment after a mode change, both directions
    do_reset();
    mode = 3'd5; dir = 1'b1; pulse(3, 4);
    mode = 3'd0; pulse(3, 4);
    expect_idx("R6", 48);
    do_reset();
    mode = 3'd5; dir = 1'b1; pulse(3, 4);
    mode = 3'd0; dir = 1'b0; pulse(3, 4);
    chk_eq("R6", "down realign lands home", int'(home_n), 0);
    mode = 3'd5; dir = 1'b1; for (int n = 0; n < 3; n++) pulse(3, 4);
    mode = 3'd2; pulse(3, 4);
    expect_idx("R6", 24);

    // R7 steps while disabled leave outputs untouched
    en_n = 1'b1;
    for (int n = 0; n < 5; n++) pulse(3, 4);
    expect_idx("R7", 24);
    en_n = 1'b0; pulse(3, 4);
    expect_idx("R7", 32);

    // R10 latency and single move for a held step
    mode = 3'd5; dir = 1'b1;
    @(negedge clk); step = 1'b1;
    @(negedge clk);
    expect_idx("R10", 32);
    @(negedge clk);
    expect_idx("R10", 32);
    @(negedge clk);
    expect_idx("R10", 33);
    repeat (30) @(negedge clk);
    expect_idx("R10", 33);
    step = 1'b0;
    repeat (4) @(negedge clk);

    // mixed stream of modes, directions and enables
    for (int n = 0; n < 400; n++) begin
      lcg  = lcg * 1103515245 + 12345;
      mode = lcg[18:16];
      dir  = lcg[20];
      en_n = (lcg[23:21] == 3'd0);
      pulse(3 + int'(lcg[25:24]), 3 + int'(lcg[27:26]));
    end
    en_n = 1'b0;

    // R7 reset mid-run forces home
    @(negedge clk); rst_n = 1'b0; run_cmp = 0;
    step = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R7", "home while reset", int'(home_n), 0);
    step = 1'b0; rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_eq("R7", "home after reset", int'(home_n), 0);
    run_cmp = 1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule